// File: doc/BRIEF.md
# Three-Channel Capture/Compare Timer

This block is a 16-bit timer with three capture/compare channels, for use as a peripheral inside a larger chip. The counter advances once per rising edge of one of four clock-source inputs. It either counts up to a period value held by channel 0 and then restarts, or it runs freely across the full 16-bit range. Channel 0 is internal only: it sets the period and raises its own flag, but it has no pad output. Channels 1 and 2 each produce a PWM or static output level, or capture the counter value on a rising edge of an input they select. Channel 1's output also serves as a converter trigger.

The capture pins for channels 1 and 2 come from one of two pin pairs, chosen by a remap bit. The outputs drive both pin pairs whatever the remap bit holds. A shutdown trigger, taken either from an internal comparator or from an external pin, latches the pad output enables off until software clears the condition. Software reaches every register through a simple write strobe and a combinational read port. Every event sets a flag, and each flag is cleared by writing a one to it.

Register map (word addresses): 0 control, 1..3 channel control 0..2, 4 flags, 5..7 channel value 0..2, 8 counter (read only). Addresses that are not listed read as zero.

Top module: `capcomp_timer3`

## Requirements
- R1: After reset the counter, control, channel control, channel value and flags registers all read 0, all interrupt outputs and PWM outputs are 0, and both output enables are 1.
- R2: Control bits [1:0] pick the count source: 0 selects clk_src[0] (external pin), 1 selects clk_src[1], 2 selects clk_src[2] and 3 selects clk_src[3] (internal). While control bit 3 (run) is 1, the counter advances by one on each rising edge of the selected source and ignores the other three sources.
- R3: With control bit 2 = 0 (up mode), a tick taken while the counter is at or above the channel 0 value returns the counter to 0. That wrap sets flag bit 0 (irq_ovf).
- R4: With control bit 2 = 1 (continuous mode), the counter goes from 0xFFFF to 0 and sets flag bit 0 at that wrap.
- R5: A channup n in compare mode (channel control bit 0 = 0) sets flag bit 1+n (irq_ch[n]) on the tick that moves the counter to its channel value.
- R6: For channels 1 and 2, channel control bit 3 = 1 selects reset/set mode: the output goes to 0 when that channel's compare fires and to 1 when the counter wraps, and the compare wins when both occur on the same tick. With bit 3 = 0 the output equals channel control bit 4. Channel 1's output also drives adc_trig.
- R7: With channel control bit 0 = 1 (capture), bits [2:1] pick the input: 0 = input A, 1 = input B (cap_b[n]), 2 = ground, 3 = supply. A rising edge of the picked input copies the counter into the channel value and sets flag bit 1+n. If that flag was already set, the edge also sets flag bit 4+n (capture overflow).
- R8: Input A of channel 0 is cap_int0. For channels 1 and 2, input A is cap_pin_pri[n-1] when control bit 4 = 0 and cap_pin_alt[n-1] when it is 1. Edges on the unselected pair are ignored.
- R9: Control bit 5 picks the shutdown trigger: 0 = hiz_cmp, 1 = hiz_pin. When the picked trigger is 1, pwm_oe becomes 0 on the next cycle. It stays 0 until a control write with bit 6 set is made while the trigger is 0.
- R10: Writing 1 to a bit of the flags register clears that flag. An event on the same cycle wins over the clear, and writing 0 leaves the flag unchanged.
- R11: A control write with bit 7 set returns the counter to 0 in the same cycle. Control bits 6 and 7 are not stored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| clk_src | input | 4 | Count sources: external pin, aux, sub, internal |
| cap_int0 | input | 1 | Channel 0 input A (internal) |
| cap_b | input | 3 | Input B of each channel |
| cap_pin_pri | input | 2 | Primary capture pins for channels 1 and 2 |
| cap_pin_alt | input | 2 | Alternate capture pins for channels 1 and 2 |
| hiz_cmp | input | 1 | Comparator shutdown trigger |
| hiz_pin | input | 1 | External-pin shutdown trigger |
| irq_ovf | output | 1 | Counter wrap flag |
| irq_ch | output | 3 | Channel event flags |
| pwm_out | output | 2 | Outputs of channels 1 and 2, driven to both pin pairs |
| pwm_oe | output | 2 | Pad output enables; 0 means high impedance |
| adc_trig | output | 1 | Channel 1 output, used as the converter trigger |

## Verification
On every cycle the assertions check that the counter only steps by one or returns to zero, and that in up mode it never passes the period. They also check that the wrap flag rises only with the counter at zero, and that a capture overflow appears only on top of a flag that was already set. Finally, they check that a flag falls only through a flags write, and that the shutdown condition is entered on the trigger and held until it is cleared. The bench's scenarios are needed for the rest: source selection, the reset/set waveform and the static level, the four capture input choices, pin-pair remapping, the two trigger sources, and the full-range wrap in continuous mode. A behavioural model, compared on every clock, covers these.

// File: rtl/capcomp_pkg.sv
package capcomp_pkg;
   localparam int NCH      = 3;
   localparam int NSRC     = 4;
   // word addresses
   localparam int A_CTL    = 0;
   localparam int A_CCTL0  = 1;
   localparam int A_FLAGS  = 4;
   localparam int A_CCR0   = 5;
   localparam int A_CNT    = 8;
   // control register bits
   localparam int CTL_CONT   = 2;
   localparam int CTL_RUN    = 3;
   localparam int CTL_REMAP  = 4;
   localparam int CTL_TRGSEL = 5;
   localparam int CTL_HIZCLR = 6;
   localparam int CTL_CLR    = 7;
   localparam int CTL_W      = 6;
   // channel control bits
   localparam int CC_CAP   = 0;
   localparam int CC_RS    = 3;
   localparam int CC_LVL   = 4;
   localparam int CC_W     = 5;
   // flags register layout
   localparam int FL_CH    = 1;
   localparam int FL_COV   = FL_CH + NCH;
   localparam int FL_W     = 1 + 2 * NCH;

   typedef enum logic [1:0] {IN_A = 2'd0, IN_B = 2'd1, IN_GND = 2'd2, IN_VCC = 2'd3} cap_sel_e;
endpackage

// File: rtl/capcomp_tick.sv
module capcomp_tick #(
   parameter int NSRC = 4,
   localparam int SW  = $clog2(NSRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic [SW-1:0]   sel,
   output logic            tick
);
   logic cur, prev;

   assign cur  = src[sel];
   assign tick = cur & ~prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= cur;
   end
endmodule

// File: rtl/capcomp_counter.sv
module capcomp_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         run,
   input  logic         cont,
   input  logic         clr,
   input  logic         ovf_clr,
   input  logic [W-1:0] period,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_nxt,
   output logic         adv,
   output logic         wrap,
   output logic         ovf
);
   always_comb begin
      adv     = tick & run & ~clr;
      wrap    = adv & (cont ? (&cnt) : (cnt >= period));
      cnt_nxt = wrap ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         if (clr)      cnt <= '0;
         else if (adv) cnt <= cnt_nxt;
         if (wrap)         ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
      end
   end
endmodule

// File: rtl/capcomp_chan.sv
module capcomp_chan
   import capcomp_pkg::*;
#(
   parameter int W       = 16,
   parameter bit HAS_PIN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv,
   input  logic           wrap,
   input  logic [W-1:0]   cnt,
   input  logic [W-1:0]   cnt_nxt,
   input  logic           cctl_we,
   input  logic           ccr_we,
   input  logic [W-1:0]   wdata,
   input  logic           flag_clr,
   input  logic           cov_clr,
   input  logic           cap_a,
   input  logic           cap_b,
   output logic [CC_W-1:0] cctl_q,
   output logic [W-1:0]   ccr_q,
   output logic           flag,
   output logic           cov,
   output logic           out
);
   logic cap_sig, cap_prev, cap_ev, cmp_ev;

   always_comb begin
      unique case (cap_sel_e'(cctl_q[2:1]))
         IN_A:    cap_sig = cap_a;
         IN_B:    cap_sig = cap_b;
         IN_GND:  cap_sig = 1'b0;
         default: cap_sig = 1'b1;
      endcase
      cap_ev = cctl_q[CC_CAP] & cap_sig & ~cap_prev;
      cmp_ev = adv & ~cctl_q[CC_CAP] & (cnt_nxt == ccr_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_prev <= 1'b0;
         cctl_q   <= '0;
         ccr_q    <= '0;
         flag     <= 1'b0;
         cov      <= 1'b0;
      end else begin
         cap_prev <= cap_sig;
         if (cctl_we) cctl_q <= wdata[CC_W-1:0];
         if (ccr_we)      ccr_q <= wdata;
         else if (cap_ev) ccr_q <= cnt;
         if (cap_ev || cmp_ev) flag <= 1'b1;
         else if (flag_clr)    flag <= 1'b0;
         if (cap_ev && flag)   cov <= 1'b1;
         else if (cov_clr)     cov <= 1'b0;
      end
   end

   generate
      if (HAS_PIN) begin : g_pin
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else if (cmp_ev) out_q <= 1'b0;
            else if (wrap)   out_q <= 1'b1;
         end
         assign out = cctl_q[CC_RS] ? out_q : cctl_q[CC_LVL];
      end else begin : g_nopin
         logic unused_pin_bits;
         assign unused_pin_bits = &{1'b0, wrap, cctl_q[CC_LVL:CC_RS]};
         assign out = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/capcomp_timer3.sv
module capcomp_timer3
   import capcomp_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [CNT_W-1:0] rd_data,
   input  logic [NSRC-1:0]  clk_src,
   input  logic             cap_int0,
   input  logic [NCH-1:0]   cap_b,
   input  logic [NCH-2:0]   cap_pin_pri,
   input  logic [NCH-2:0]   cap_pin_alt,
   input  logic             hiz_cmp,
   input  logic             hiz_pin,
   output logic             irq_ovf,
   output logic [NCH-1:0]   irq_ch,
   output logic [NCH-2:0]   pwm_out,
   output logic [NCH-2:0]   pwm_oe,
   output logic             adc_trig
);
   generate
      if (CNT_W < 8) begin : g_bad_width
         $error("capcomp_timer3: CNT_W must be at least 8");
      end
      if (AW < 4) begin : g_bad_aw
         $error("capcomp_timer3: AW must be at least 4");
      end
   endgenerate

   logic [CTL_W-1:0] ctl_q;
   logic             ctl_we, flg_we, cnt_clr, tick, adv, wrap, ovf, hiz_q, trig;
   logic [CNT_W-1:0] cnt_q, cnt_nxt, period;
   logic [CC_W-1:0]  cctl_q [NCH];
   logic [CNT_W-1:0] ccr_q  [NCH];
   logic [NCH-1:0]   flag, cov, ch_out, ch_cap_a;
   logic [FL_W-1:0]  flags;
   logic             ch0_cap;

   assign ctl_we  = wr_en && (wr_addr == AW'(A_CTL));
   assign flg_we  = wr_en && (wr_addr == AW'(A_FLAGS));
   assign cnt_clr = ctl_we && wr_data[CTL_CLR];
   assign period  = ccr_q[0];
   assign ch0_cap = cctl_q[0][CC_CAP];
   assign flags   = {cov, flag, ovf};
   assign trig    = ctl_q[CTL_TRGSEL] ? hiz_pin : hiz_cmp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         hiz_q <= 1'b0;
      end else begin
         if (ctl_we) ctl_q <= wr_data[CTL_W-1:0];
         if (trig) hiz_q <= 1'b1;
         else if (ctl_we && wr_data[CTL_HIZCLR]) hiz_q <= 1'b0;
      end
   end

   capcomp_tick #(.NSRC(NSRC)) u_tick (
      .clk(clk), .rst_n(rst_n), .src(clk_src), .sel(ctl_q[1:0]), .tick(tick)
   );

   capcomp_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctl_q[CTL_RUN]),
      .cont(ctl_q[CTL_CONT]), .clr(cnt_clr), .ovf_clr(flg_we && wr_data[0]),
      .period(period), .cnt(cnt_q), .cnt_nxt(cnt_nxt), .adv(adv),
      .wrap(wrap), .ovf(ovf)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_ch
         if (gi == 0) begin : g_int
            assign ch_cap_a[gi] = cap_int0;
         end else begin : g_pad
            assign ch_cap_a[gi] = ctl_q[CTL_REMAP] ? cap_pin_alt[gi-1] : cap_pin_pri[gi-1];
         end
         capcomp_chan #(.W(CNT_W), .HAS_PIN(gi != 0)) u_chan (
            .clk(clk), .rst_n(rst_n), .adv(adv), .wrap(wrap), .cnt(cnt_q),
            .cnt_nxt(cnt_nxt),
            .cctl_we(wr_en && (wr_addr == AW'(A_CCTL0 + gi))),
            .ccr_we(wr_en && (wr_addr == AW'(A_CCR0 + gi))),
            .wdata(wr_data),
            .flag_clr(flg_we && wr_data[FL_CH + gi]),
            .cov_clr(flg_we && wr_data[FL_COV + gi]),
            .cap_a(ch_cap_a[gi]), .cap_b(cap_b[gi]),
            .cctl_q(cctl_q[gi]), .ccr_q(ccr_q[gi]), .flag(flag[gi]),
            .cov(cov[gi]), .out(ch_out[gi])
         );
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr == AW'(A_CTL))   rd_data = CNT_W'(ctl_q);
      if (rd_addr == AW'(A_FLAGS)) rd_data = CNT_W'(flags);
      if (rd_addr == AW'(A_CNT))   rd_data = cnt_q;
      for (int i = 0; i < NCH; i++) begin
         if (rd_addr == AW'(A_CCTL0 + i)) rd_data = CNT_W'(cctl_q[i]);
         if (rd_addr == AW'(A_CCR0 + i))  rd_data = ccr_q[i];
      end
   end

   assign irq_ovf  = ovf;
   assign irq_ch   = flag;
   assign pwm_out  = ch_out[NCH-1:1];
   assign pwm_oe   = {(NCH-1){~hiz_q}};
   assign adc_trig = ch_out[1];
endmodule

// File: rtl/capcomp_timer3_chk.sv
module capcomp_timer3_chk
   import capcomp_pkg::*;
#(
   parameter int W  = 16,
   parameter int AW = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [AW-1:0]   wr_addr,
   input logic [W-1:0]    wr_data,
   input logic [CTL_W-1:0] ctl,
   input logic            ch0_cap,
   input logic [W-1:0]    period,
   input logic [W-1:0]    cnt,
   input logic [FL_W-1:0] flags,
   input logic            hiz_cmp,
   input logic            hiz_pin,
   input logic [NCH-2:0]  pwm_oe
);
   logic trig_sel;
   assign trig_sel = ctl[CTL_TRGSEL] ? hiz_pin : hiz_cmp;

   // R2: the counter steps by one or returns to zero
   a_r2_step_or_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == W'($past(cnt) + 1'b1) || cnt == '0));

   // R3: in up mode the counter stays within the period
   a_r3_up_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !ch0_cap && !ctl[CTL_CONT] && cnt <= period) |=> (cnt <= $past(period)));

   // R3: the wrap flag rises only with the counter at zero
   a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> (cnt == '0));

   // R9: the picked trigger disables outputs on the next cycle
   a_r9_hiz_enter: assert property (@(posedge clk) disable iff (!rst_n)
      trig_sel |=> (pwm_oe == '0));

   // R9: the disabled state holds without a clear write
   a_r9_hiz_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_oe == '0 && !(wr_en && wr_addr == AW'(A_CTL) && wr_data[CTL_HIZCLR])) |=> (pwm_oe == '0));

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_ch
         // R7: capture overflow only on top of a set flag
         a_r7_cov_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[FL_COV + gi]) |-> $past(flags[FL_CH + gi]));
      end
      for (gi = 0; gi < FL_W; gi++) begin : g_fl
         // R10: a flag falls only through a flags write
         a_r10_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[gi]) |-> $past(wr_en && wr_addr == AW'(A_FLAGS) && wr_data[gi]));
      end
   endgenerate
endmodule

bind capcomp_timer3 capcomp_timer3_chk #(.W(CNT_W), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .ctl(ctl_q), .ch0_cap(ch0_cap), .period(period), .cnt(cnt_q), .flags(flags),
   .hiz_cmp(hiz_cmp), .hiz_pin(hiz_pin), .pwm_oe(pwm_oe)
);

// File: tb/tb_capcomp_timer3.sv
module tb_capcomp_timer3;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [3:0]  clk_src = '0;
   logic        cap_int0 = 1'b0;
   logic [2:0]  cap_b = '0;
   logic [1:0]  cap_pin_pri = '0;
   logic [1:0]  cap_pin_alt = '0;
   logic        hiz_cmp = 1'b0;
   logic        hiz_pin = 1'b0;
   logic        irq_ovf;
   logic [2:0]  irq_ch;
   logic [1:0]  pwm_out, pwm_oe;
   logic        adc_trig;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   capcomp_timer3 dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .clk_src(clk_src), .cap_int0(cap_int0),
      .cap_b(cap_b), .cap_pin_pri(cap_pin_pri), .cap_pin_alt(cap_pin_alt),
      .hiz_cmp(hiz_cmp), .hiz_pin(hiz_pin), .irq_ovf(irq_ovf), .irq_ch(irq_ch),
      .pwm_out(pwm_out), .pwm_oe(pwm_oe), .adc_trig(adc_trig)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [5:0]  m_ctl;
   logic [4:0]  m_cctl [3];
   logic [15:0] m_ccr  [3];
   logic [15:0] m_cnt;
   logic        m_ovf, m_hiz, m_sprev;
   logic [2:0]  m_flag, m_cov, m_oq, m_cprev;

   function automatic logic [15:0] m_read(input logic [3:0] a);
      case (a)
         4'd0: return {10'd0, m_ctl};
         4'd1, 4'd2, 4'd3: return {11'd0, m_cctl[a - 1]};
         4'd4: return {9'd0, m_cov, m_flag, m_ovf};
         4'd5, 4'd6, 4'd7: return m_ccr[a - 5];
         4'd8: return m_cnt;
         default: return 16'd0;
      endcase
   endfunction

   function automatic logic m_pwm(input int ch);
      return m_cctl[ch][3] ? m_oq[ch] : m_cctl[ch][4];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = '0; m_cnt = '0; m_ovf = 0; m_hiz = 0; m_sprev = 0;
         m_flag = '0; m_cov = '0; m_oq = '0; m_cprev = '0;
         for (int c = 0; c < 3; c++) begin m_cctl[c] = '0; m_ccr[c] = '0; end
      end else begin
         logic sv, tk, ctlw, flw, cl, adv, wrp, trig, s, capv, cmpv, oldf;
         logic [15:0] nx;
         sv   = clk_src[m_ctl[1:0]];
         tk   = sv && !m_sprev;
         m_sprev = sv;
         ctlw = wr_en && wr_addr == 4'd0;
         flw  = wr_en && wr_addr == 4'd4;
         cl   = ctlw && wr_data[7];
         adv  = tk && m_ctl[3] && !cl;
         wrp  = adv && (m_ctl[2] ? (m_cnt == 16'hFFFF) : (m_cnt >= m_ccr[0]));
         nx   = wrp ? 16'd0 : m_cnt + 16'd1;
         trig = m_ctl[5] ? hiz_pin : hiz_cmp;
         for (int c = 0; c < 3; c++) begin
            logic a;
            int   pi;
            pi = (c == 0) ? 0 : c - 1;
            a  = (c == 0) ? cap_int0 : (m_ctl[4] ? cap_pin_alt[pi] : cap_pin_pri[pi]);
            case (m_cctl[c][2:1])
               2'd0: s = a;
               2'd1: s = cap_b[c];
               2'd2: s = 1'b0;
               default: s = 1'b1;
            endcase
            capv = m_cctl[c][0] && s && !m_cprev[c];
            m_cprev[c] = s;
            cmpv = adv && !m_cctl[c][0] && (nx == m_ccr[c]);
            oldf = m_flag[c];
            if (flw && wr_data[1 + c]) m_flag[c] = 1'b0;
            if (capv || cmpv) m_flag[c] = 1'b1;
            if (flw && wr_data[4 + c]) m_cov[c] = 1'b0;
            if (capv && oldf) m_cov[c] = 1'b1;
            if (wrp) m_oq[c] = 1'b1;
            if (cmpv) m_oq[c] = 1'b0;
            if (capv) m_ccr[c] = m_cnt;
            if (wr_en && wr_addr == 4'(5 + c)) m_ccr[c] = wr_data;
            if (wr_en && wr_addr == 4'(1 + c)) m_cctl[c] = wr_data[4:0];
         end
         if (flw && wr_data[0]) m_ovf = 1'b0;
         if (wrp) m_ovf = 1'b1;
         if (cl) m_cnt = '0;
         else if (adv) m_cnt = nx;
         if (trig) m_hiz = 1'b1;
         else if (ctlw && wr_data[6]) m_hiz = 1'b0;
         if (ctlw) m_ctl = wr_data[5:0];
      end
   end

   // every-clock comparison, sampled after the edge has settled
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk(irq_ovf === m_ovf, "R3/R4 irq_ovf model", 32'(irq_ovf), 32'(m_ovf));
         chk(irq_ch === m_flag, "R5/R7 irq_ch model", 32'(irq_ch), 32'(m_flag));
         chk(pwm_out === {m_pwm(2), m_pwm(1)}, "R6 pwm_out model", 32'(pwm_out), 32'({m_pwm(2), m_pwm(1)}));
         chk(adc_trig === m_pwm(1), "R6 adc_trig model", 32'(adc_trig), 32'(m_pwm(1)));
         chk(pwm_oe === (m_hiz ? 2'b00 : 2'b11), "R9 pwm_oe model", 32'(pwm_oe), m_hiz ? 32'd0 : 32'd3);
         chk(rd_data === m_read(rd_addr), "R2/R10 rd_data model", 32'(rd_data), 32'(m_read(rd_addr)));
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] v);
      @(negedge clk); rd_addr = a;
      @(posedge clk); #3; v = rd_data;
   endtask

   task automatic pulse_src(input int idx, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); clk_src[idx] = 1'b1;
         @(negedge clk); clk_src[idx] = 1'b0;
      end
   endtask

   task automatic pulse_pri(input int idx);
      @(negedge clk); cap_pin_pri[idx] = 1'b1;
      @(negedge clk); cap_pin_pri[idx] = 1'b0;
   endtask

   task automatic pulse_alt(input int idx);
      @(negedge clk); cap_pin_alt[idx] = 1'b1;
      @(negedge clk); cap_pin_alt[idx] = 1'b0;
   endtask

   task automatic pulse_b(input int idx);
      @(negedge clk); cap_b[idx] = 1'b1;
      @(negedge clk); cap_b[idx] = 1'b0;
   endtask

   initial begin
      #(195000 * 10);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(4'd8, v); chk(v == 16'd0, "R1 counter after reset", v, 0);
      rd(4'd0, v); chk(v == 16'd0, "R1 control after reset", v, 0);
      rd(4'd4, v); chk(v == 16'd0, "R1 flags after reset", v, 0);
      chk(irq_ovf == 1'b0 && irq_ch == 3'd0, "R1 interrupts after reset", {irq_ovf, irq_ch}, 0);
      chk(pwm_oe == 2'b11 && pwm_out == 2'b00, "R1 outputs after reset", {pwm_oe, pwm_out}, 32'hC);

      // R2: source 1 selected, continuous, run; other sources ignored
      wr(4'd0, 16'h000D);
      pulse_src(0, 3); pulse_src(2, 3); pulse_src(1, 5);
      rd(4'd8, v); chk(v == 16'd5, "R2 count on selected source", v, 5);
      wr(4'd0, 16'h000F);
      pulse_src(1, 2); pulse_src(3, 2);
      rd(4'd8, v); chk(v == 16'd7, "R2 count after source change", v, 7);

      // R11: counter clear bit, bits 6 and 7 not stored
      wr(4'd0, 16'h00CF);
      rd(4'd8, v); chk(v == 16'd0, "R11 counter cleared", v, 0);
      rd(4'd0, v); chk(v == 16'h000F, "R11 control readback", v, 16'h000F);
      wr(4'd0, 16'h004F);

      // R3, R5: up mode with period 3
      wr(4'd4, 16'h007F);
      wr(4'd5, 16'd3);
      wr(4'd0, 16'h000B);
      pulse_src(3, 3);
      rd(4'd8, v); chk(v == 16'd3, "R3 count reaches period", v, 3);
      chk(irq_ch == 3'b001 && irq_ovf == 1'b0, "R5 channel 0 compare flag", {irq_ovf, irq_ch}, 1);
      pulse_src(3, 1);
      rd(4'd8, v); chk(v == 16'd0, "R3 wrap to zero", v, 0);
      chk(irq_ovf == 1'b1, "R3 wrap flag", irq_ovf, 1);
      chk(irq_ch == 3'b111, "R5 compare flags at zero", irq_ch, 7);

      // R10: write-one-to-clear
      wr(4'd4, 16'h0001);
      chk(irq_ovf == 1'b0 && irq_ch == 3'b111, "R10 selective clear", {irq_ovf, irq_ch}, 7);
      wr(4'd4, 16'h000E);
      chk(irq_ch == 3'b000, "R10 channel flags cleared", irq_ch, 0);

      // R6: reset/set output on channel 1, static level on channel 2
      wr(4'd2, 16'h0008);
      wr(4'd6, 16'd2);
      pulse_src(3, 4);
      chk(pwm_out[0] == 1'b1 && adc_trig == 1'b1, "R6 set at wrap", {pwm_out[0], adc_trig}, 3);
      pulse_src(3, 2);
      chk(pwm_out[0] == 1'b0 && adc_trig == 1'b0, "R6 reset at compare", {pwm_out[0], adc_trig}, 0);
      wr(4'd3, 16'h0010);
      chk(pwm_out[1] == 1'b1, "R6 static level", pwm_out[1], 1);

      // R7: capture on input A, then capture overflow
      wr(4'd3, 16'h0001);
      wr(4'd4, 16'h007F);
      pulse_pri(1);
      rd(4'd7, v); chk(v == 16'd2, "R7 captured value", v, 2);
      chk(irq_ch[2] == 1'b1, "R7 capture flag", irq_ch[2], 1);
      pulse_src(3, 1);
      pulse_pri(1);
      rd(4'd7, v); chk(v == 16'd3, "R7 second capture", v, 3);
      rd(4'd4, v); chk((v & 16'h0048) == 16'h0048, "R7 capture overflow bit", v, 16'h0048);

      // R7: input B and ground selections
      pulse_src(3, 1);
      wr(4'd3, 16'h0003);
      pulse_b(2);
      rd(4'd7, v); chk(v == 16'd0, "R7 capture from input B", v, 0);
      pulse_src(3, 1);
      wr(4'd3, 16'h0005);
      pulse_pri(1); pulse_b(2);
      rd(4'd7, v); chk(v == 16'd0, "R7 ground input never captures", v, 0);

      // R8: remap to alternate pins
      wr(4'd3, 16'h0001);
      wr(4'd4, 16'h007F);
      wr(4'd0, 16'h001B);
      pulse_pri(1);
      rd(4'd7, v); chk(v == 16'd0 && irq_ch[2] == 1'b0, "R8 primary pin ignored", {v, irq_ch[2]}, 0);
      pulse_alt(1);
      rd(4'd7, v); chk(v == 16'd1, "R8 alternate pin captures", v, 1);

      // R9: shutdown trigger selection, latching and clearing
      @(negedge clk); hiz_pin = 1'b1;
      @(negedge clk); hiz_pin = 1'b0;
      chk(pwm_oe == 2'b11, "R9 unselected pin ignored", pwm_oe, 3);
      @(negedge clk); hiz_cmp = 1'b1;
      @(negedge clk); hiz_cmp = 1'b0;
      @(negedge clk);
      chk(pwm_oe == 2'b00, "R9 comparator latches off", pwm_oe, 0);
      wr(4'd0, 16'h005B);
      chk(pwm_oe == 2'b11, "R9 cleared by write", pwm_oe, 3);
      wr(4'd0, 16'h003B);
      @(negedge clk); hiz_pin = 1'b1;
      wr(4'd0, 16'h007B);
      chk(pwm_oe == 2'b00, "R9 clear ignored while trigger high", pwm_oe, 0);
      @(negedge clk); hiz_pin = 1'b0;
      wr(4'd0, 16'h007B);
      chk(pwm_oe == 2'b11, "R9 cleared after trigger low", pwm_oe, 3);

      // R4: continuous full-range wrap
      wr(4'd0, 16'h008D);
      wr(4'd4, 16'h007F);
      pulse_src(1, 65535);
      rd(4'd8, v); chk(v == 16'hFFFF, "R4 count at top", v, 16'hFFFF);
      chk(irq_ovf == 1'b0, "R4 no wrap flag before top", irq_ovf, 0);
      pulse_src(1, 1);
      rd(4'd8, v); chk(v == 16'd0, "R4 wrap to zero", v, 0);
      chk(irq_ovf == 1'b1, "R4 wrap flag", irq_ovf, 1);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule